// File: doc/BRIEF.md
# Thermometer-to-Binary Result Encoder

This block turns the word produced by a bank of parallel threshold comparators into a binary count. The comparators have ladder thresholds, so a result `s` lights the lowest `s` bits of the word and leaves the rest clear. Bit 0 is the comparator with the lowest threshold.

The conversion runs in three combinational stages, and their result is registered once:

- **Edge stage:** marks the single place where the word steps from 1 to 0. Each bit is ANDed with the inverse of its upper neighbour, and the top bit is compared against an implied 0.
- **Row encoder:** turns the resulting one-hot line into a binary value. Line `k` stands for `(k+1) mod N`, so a full-scale word wraps to zero.
- **Shape check:** runs in parallel and flags any word that is not a legal thermometer pattern.

A producer presents a word with a valid strobe. One clock later the count, the error flag and a matching valid strobe appear at the outputs. With no strobe, the count and the flag keep their last values.

Top module: `therm_result_encoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `out_count` and `out_err` are all 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: A valid word whose lowest `s` bits are 1 and whose other bits are 0, with 1 <= s <= N-1, gives `out_count` = s and `out_err` = 0 one cycle later.
- R4: A valid all-ones word (s = N) gives `out_count` = 0 and `out_err` = 0 one cycle later.
- R5: A valid all-zero word gives `out_count` = 0 and `out_err` = 0 one cycle later.
- R6: A 1-to-0 step is detected at bit k when bit k is 1 and bit k+1 is 0. Bit N-1 is taken as followed by a 0. A step at bit k selects the row value (k+1) mod N.
- R7: A valid word that has some bit k at 0 with bit k+1 at 1 is not a thermometer code. It gives `out_err` = 1 one cycle later, and `out_count` is the bitwise OR of the row values of all steps found by R6.
- R8: In a cycle where `in_valid` is 0, `out_count` and `out_err` keep the values they had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe qualifying `in_word` |
| in_word | input | N (8) | Comparator word, bit 0 = lowest threshold |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_count | output | $clog2(N) (3) | Encoded count |
| out_err | output | 1 | Input was not a thermometer code |

## Verification
Every result is due exactly one rising edge after the word that caused it. The only exception is the held values of R8, which must stay unchanged across every cycle without a strobe.

The bench drives each word on a falling edge and keeps a behavioural model that computes the expected outputs from that word alone. At the next falling edge, after the single register stage has loaded, it compares count, flag and valid against the model. Because the check is made on every clock, back-to-back words, idle gaps and the cycle after reset are all covered at their due cycle.

// File: rtl/therm_pkg.sv
package therm_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // Binary value carried by the row that a step at position k selects.
    function automatic int unsigned row_value(input int unsigned k, input int unsigned n);
        return (k + 1) % n;
    endfunction

    typedef enum logic [1:0] {
        SHAPE_ZERO  = 2'd0,
        SHAPE_THERM = 2'd1,
        SHAPE_FULL  = 2'd2,
        SHAPE_BAD   = 2'd3
    } shape_e;

endpackage

// File: rtl/therm_edge_detect.sv
module therm_edge_detect #(
    parameter int unsigned N = therm_pkg::DEF_WIDTH
) (
    input  logic [N-1:0] word_i,
    output logic [N-1:0] step_o
);
    // A step sits where a set bit is followed by a clear one.
    // The top bit sees a clear bit beyond the end of the word.
    for (genvar k = 0; k < N; k++) begin : g_step
        if (k == N - 1) begin : g_top
            assign step_o[k] = word_i[k];
        end else begin : g_mid
            assign step_o[k] = word_i[k] & ~word_i[k+1];
        end
    end
endmodule

// File: rtl/therm_shape_check.sv
module therm_shape_check #(
    parameter int unsigned N = therm_pkg::DEF_WIDTH
) (
    input  logic [N-1:0]     word_i,
    output therm_pkg::shape_e shape_o
);
    import therm_pkg::*;

    logic [N-2:0] rise;   // clear bit below a set bit: illegal
    logic         bad;

    assign rise = ~word_i[N-2:0] & word_i[N-1:1];
    assign bad  = |rise;

    always_comb begin
        if (bad)                shape_o = SHAPE_BAD;
        else if (&word_i)       shape_o = SHAPE_FULL;
        else if (word_i == '0)  shape_o = SHAPE_ZERO;
        else                    shape_o = SHAPE_THERM;
    end
endmodule

// File: rtl/therm_row_encoder.sv
module therm_row_encoder #(
    parameter int unsigned N  = therm_pkg::DEF_WIDTH,
    parameter int unsigned CW = $clog2(N)
) (
    input  logic [N-1:0]  step_i,
    output logic [CW-1:0] code_o
);
    import therm_pkg::*;

    logic [CW-1:0] gated [N];

    for (genvar k = 0; k < N; k++) begin : g_row
        localparam logic [CW-1:0] ROW = CW'(row_value(k, N));
        assign gated[k] = step_i[k] ? ROW : '0;
    end

    always_comb begin
        code_o = '0;
        for (int k = 0; k < N; k++) begin
            code_o = code_o | gated[k];
        end
    end
endmodule

// File: rtl/therm_result_encoder.sv
module therm_result_encoder #(
    parameter int unsigned N  = therm_pkg::DEF_WIDTH,
    parameter int unsigned CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [N-1:0]  in_word,
    output logic          out_valid,
    output logic [CW-1:0] out_count,
    output logic          out_err
);
    import therm_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] count;
        logic          err;
    } result_t;

    logic [N-1:0]  step;
    logic [CW-1:0] code;
    shape_e        shape;
    result_t       res_q;

    therm_edge_detect #(.N(N)) u_edge (
        .word_i (in_word),
        .step_o (step)
    );

    therm_shape_check #(.N(N)) u_shape (
        .word_i  (in_word),
        .shape_o (shape)
    );

    therm_row_encoder #(.N(N), .CW(CW)) u_rows (
        .step_i (step),
        .code_o (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= in_valid;
            if (in_valid) begin
                res_q.count <= code;
                res_q.err   <= (shape == SHAPE_BAD);
            end
        end
    end

    assign out_valid = res_q.vld;
    assign out_count = res_q.count;
    assign out_err   = res_q.err;
endmodule

// File: rtl/therm_result_encoder_chk.sv
module therm_result_encoder_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [N-1:0]  in_word,
    input logic          out_valid,
    input logic [CW-1:0] out_count,
    input logic          out_err
);
    logic [N-1:0] word_inc;
    logic         legal;
    assign word_inc = in_word + N'(1);
    assign legal    = ((in_word & word_inc) == '0);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_therm_count_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal && in_word != '0) |=>
            (out_count == CW'($countones($past(in_word)) % N)) && !out_err);

    assert_full_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_word)) |=> (out_count == '0) && !out_err);

    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word == '0) |=> (out_count == '0) && !out_err);

    assert_bad_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legal) |=> out_err);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_count) && $stable(out_err));
endmodule

bind therm_result_encoder therm_result_encoder_chk #(.N(N), .CW(CW)) i_chk (.*);

// File: tb/test_therm_result_encoder.sv
module test_therm_result_encoder;
    localparam int N  = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_word = '0;
    logic          out_valid;
    logic [CW-1:0] out_count;
    logic          out_err;

    int    n_vec  = 0;
    int    n_fail = 0;
    logic          exp_valid = 1'b0;
    logic [CW-1:0] exp_count = '0;
    logic          exp_err   = 1'b0;
    string         exp_tag   = "R1";

    always #4 clk = ~clk;

    therm_result_encoder #(.N(N), .CW(CW)) i_therm_result_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_count(out_count), .out_err(out_err)
    );

    // Behavioural model of R3..R7.
    task automatic model(input logic [N-1:0] w, output logic [CW-1:0] cnt,
                         output logic err, output string tag);
        int v;
        int ones;
        int acc;
        v    = int'(w);
        ones = 0;
        for (int k = 0; k < N; k++) ones += int'(w[k]);
        if (((v & (v + 1)) & ((1 << N) - 1)) != 0) begin
            acc = 0;
            for (int k = 0; k < N; k++) begin
                if (w[k] && (k == N - 1 || !w[k+1])) acc = acc | ((k + 1) % N);
            end
            cnt = CW'(acc); err = 1'b1; tag = "R7";
        end else begin
            cnt = CW'(ones % N); err = 1'b0;
            if (ones == 0)      tag = "R5";
            else if (ones == N) tag = "R4";
            else                tag = "R3";
        end
    endtask

    task automatic check();
        n_vec++;
        if (out_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, exp_valid);
        end
        if (out_count !== exp_count || out_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s count/err actual %0d/%0b expected %0d/%0b",
                     exp_tag, out_count, out_err, exp_count, exp_err);
        end
    endtask

    task automatic step(input logic v, input logic [N-1:0] w);
        @(negedge clk);
        check();
        in_valid = v;
        in_word  = w;
        exp_valid = v;
        if (v) model(w, exp_count, exp_err, exp_tag);
        else   exp_tag = "R8";
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [N-1:0] lfsr;
        lfsr = 8'hA7;
        // R1: reset state, during reset and on the first cycle after it
        @(negedge clk); check();
        @(negedge clk); check();
        rst = 1'b0;
        step(1'b0, '0);
        // R3, R4, R5, R6: every thermometer level
        for (int s = 0; s <= N; s++) step(1'b1, N'((1 << s) - 1));
        // R8: idle cycles with changing data must hold
        step(1'b0, 8'h3C);
        step(1'b0, 8'hFF);
        step(1'b1, 8'h1F);
        step(1'b0, 8'h00);
        step(1'b0, 8'hA5);
        // R7: non-thermometer words
        step(1'b1, 8'h02);
        step(1'b1, 8'hA5);
        step(1'b1, 8'h81);
        step(1'b1, 8'hF0);
        step(1'b1, 8'h55);
        step(1'b1, 8'h07);
        step(1'b0, 8'h00);
        // mixed pseudo-random traffic
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[1]) step(lfsr[0], N'((1 << (i % (N + 1))) - 1));
            else         step(lfsr[2] | lfsr[0], lfsr);
        end
        step(1'b0, '0);
        step(1'b0, '0);
        finish_run();
    end
endmodule